// File: doc/BRIEF.md
# Lowest-Priority Interrupt Target Selector

This block takes one interrupt request at a time and picks the single core that should service it. It serves a pool of up to 64 cores. Each request brings a bit vector naming the cores allowed to take it and the interrupt's own 8-bit priority. Every core continuously reports its current 8-bit operating priority and a ready flag. The selector chooses the permitted, ready core that is running at the lowest priority, provided that priority is strictly below the interrupt's. It reports that core's 6-bit number together with a one-hot grant vector. When no core qualifies it raises a miss pulse instead of waiting, so the caller can push the request back into its queue as a miss event.

The choice is made by a two-level registered comparison tree. The first level splits the pool into groups of eight and finds the lowest-priority eligible core in each group. It is captured on the acceptance edge. The second level picks the best group on the next edge and registers the result. The result is therefore visible for exactly one cycle, starting two clock edges after the request is accepted.

A small controller sequences the work through three states. ST_IDLE waits with `req_ready` high. The transition IDLE->REDUCE is taken on an accepted request. ST_REDUCE runs the second comparison level with `req_ready` low, and the transition REDUCE->REPORT is unconditional. ST_REPORT presents the result with `req_ready` high again. From ST_REPORT the controller goes REPORT->REDUCE when a new request is accepted in that cycle, or REPORT->IDLE when none is.

Top module: `lpri_target_sel`

## Requirements
- R1: Core i is eligible only when `req_mask[i]` is 1, `core_rdy[i]` is 1, and its priority `core_pri_bus[8*i+7:8*i]` (unsigned) is strictly less than `req_pri`. A core whose priority equals `req_pri` is not eligible, and `req_pri` = 0 always gives a miss.
- R2: Among eligible cores, the one with the numerically smallest priority is granted, and `out_core_id` carries its index.
- R3: When several eligible cores share that lowest priority, the one with the smallest index is granted.
- R4: When no core is eligible, `out_miss` pulses and `out_grant_valid` stays 0. `out_grant_vec` is all zeros and `out_core_id` is 0.
- R5: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. Exactly one of `out_grant_valid` or `out_miss` is 1 during the single cycle that follows the second rising edge after acceptance, and both are 0 at every other time.
- R6: During a grant, `out_grant_vec` has exactly one bit set, at position `out_core_id`.
- R7: `req_ready` is 0 in the cycle following an acceptance and 1 otherwise. A new request can therefore be accepted in the cycle where the previous result is shown.
- R8: The mask, ready flags and core priorities are sampled only at the acceptance edge. Changing them afterwards does not alter that request's result.
- R9: Synchronous active-high `rst` clears `out_grant_valid` and `out_miss` and leaves `req_ready` at 1.
- R10: `out_grant_valid` and `out_miss` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Selector can accept a request |
| req_mask | input | 64 | One bit per core permitted to take the request |
| req_pri | input | 8 | Priority of the interrupt |
| core_pri_bus | input | 512 | Current priority of each core, 8 bits per core, core i at bits 8*i+7..8*i |
| core_rdy | input | 64 | Per-core ready flag |
| out_grant_valid | output | 1 | One-cycle pulse: a core was chosen |
| out_miss | output | 1 | One-cycle pulse: no core could take the request |
| out_core_id | output | 6 | Index of the chosen core |
| out_grant_vec | output | 64 | One-hot mask of the chosen core, zero on a miss |

## Verification
A wrong group winner or a corrupted stage-one register shows up as a wrong `out_core_id` or grant vector in the single result cycle, two edges after acceptance. It also shows up when a miss appears where a grant is expected. A controller stuck in the wrong state shows up one cycle after acceptance as `req_ready` at the wrong level. It also shows up as a result pulse that is missing, doubled or shifted by a cycle. Sampling faults are exposed by changing core priorities right after acceptance and expecting the original winner.

// File: rtl/lpts_pkg.sv
package lpts_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REDUCE = 2'd1,
        ST_REPORT = 2'd2
    } lpts_state_e;
endpackage

// File: rtl/lpts_elig.sv
module lpts_elig #(
    parameter int NUM_CORES = 64,
    parameter int PRI_W     = 8
) (
    input  logic [NUM_CORES-1:0]       cand_mask,
    input  logic [NUM_CORES-1:0]       cand_rdy,
    input  logic [NUM_CORES*PRI_W-1:0] cand_pri,
    input  logic [PRI_W-1:0]           irq_pri,
    output logic [NUM_CORES-1:0]       elig
);
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        assign elig[i] = cand_mask[i] && cand_rdy[i] &&
                         (cand_pri[i*PRI_W +: PRI_W] < irq_pri);
    end
endmodule

// File: rtl/lpts_min_sel.sv
module lpts_min_sel #(
    parameter int N     = 8,
    parameter int PRI_W = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]       cand_vld,
    input  logic [N*PRI_W-1:0] cand_pri,
    output logic               any_vld,
    output logic [PRI_W-1:0]   best_pri,
    output logic [IDX_W-1:0]   best_idx
);
    always_comb begin
        any_vld  = 1'b0;
        best_pri = '1;
        best_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (cand_vld[i] && (!any_vld || (cand_pri[i*PRI_W +: PRI_W] < best_pri))) begin
                any_vld  = 1'b1;
                best_pri = cand_pri[i*PRI_W +: PRI_W];
                best_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lpts_ctrl.sv
module lpts_ctrl
    import lpts_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    output logic        load_s1,
    output logic        load_out,
    output lpts_state_e state_o
);
    lpts_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_REDUCE;
            ST_REDUCE: state_d = ST_REPORT;
            ST_REPORT: state_d = req_valid ? ST_REDUCE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        load_out  = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_REDUCE: load_out  = 1'b1;
            ST_REPORT: req_ready = 1'b1;
            default:   req_ready = 1'b0;
        endcase
        load_s1 = req_ready && req_valid;
    end

    assign state_o = state_q;

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R7
    AST_READY_RETURNS: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> req_ready); // R7
endmodule

// File: rtl/lpri_target_sel.sv
module lpri_target_sel
    import lpts_pkg::*;
#(
    parameter int NUM_CORES  = 64,
    parameter int PRI_W      = 8,
    parameter int GROUP_SIZE = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [NUM_CORES-1:0]          req_mask,
    input  logic [PRI_W-1:0]              req_pri,
    input  logic [NUM_CORES*PRI_W-1:0]    core_pri_bus,
    input  logic [NUM_CORES-1:0]          core_rdy,
    output logic                          out_grant_valid,
    output logic                          out_miss,
    output logic [$clog2(NUM_CORES)-1:0]  out_core_id,
    output logic [NUM_CORES-1:0]          out_grant_vec
);
    localparam int ID_W     = $clog2(NUM_CORES);
    localparam int NUM_GRPS = NUM_CORES / GROUP_SIZE;
    localparam int LIDX_W   = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1;
    localparam int GIDX_W   = (NUM_GRPS > 1) ? $clog2(NUM_GRPS) : 1;

    logic        load_s1, load_out;
    lpts_state_e state;

    lpts_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .load_s1   (load_s1),
        .load_out  (load_out),
        .state_o   (state)
    );

    logic [NUM_CORES-1:0] elig;

    lpts_elig #(.NUM_CORES(NUM_CORES), .PRI_W(PRI_W)) u_elig (
        .cand_mask (req_mask),
        .cand_rdy  (core_rdy),
        .cand_pri  (core_pri_bus),
        .irq_pri   (req_pri),
        .elig      (elig)
    );

    // first comparison level: one winner per group
    logic [NUM_GRPS-1:0]        g_any;
    logic [NUM_GRPS*PRI_W-1:0]  g_pri;
    logic [NUM_GRPS*LIDX_W-1:0] g_lidx;

    for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
        lpts_min_sel #(.N(GROUP_SIZE), .PRI_W(PRI_W), .IDX_W(LIDX_W)) u_min (
            .cand_vld (elig[g*GROUP_SIZE +: GROUP_SIZE]),
            .cand_pri (core_pri_bus[g*GROUP_SIZE*PRI_W +: GROUP_SIZE*PRI_W]),
            .any_vld  (g_any[g]),
            .best_pri (g_pri[g*PRI_W +: PRI_W]),
            .best_idx (g_lidx[g*LIDX_W +: LIDX_W])
        );
    end

    logic [NUM_GRPS-1:0]        s1_any;
    logic [NUM_GRPS*PRI_W-1:0]  s1_pri;
    logic [NUM_GRPS*LIDX_W-1:0] s1_lidx;
    logic [PRI_W-1:0]           s1_req_pri;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_any     <= '0;
            s1_pri     <= '0;
            s1_lidx    <= '0;
            s1_req_pri <= '0;
        end else if (load_s1) begin
            s1_any     <= g_any;
            s1_pri     <= g_pri;
            s1_lidx    <= g_lidx;
            s1_req_pri <= req_pri;
        end
    end

    // second comparison level: best group
    logic              s2_hit;
    logic [PRI_W-1:0]  s2_pri;
    logic [GIDX_W-1:0] s2_gidx;
    logic [LIDX_W-1:0] s2_lidx;
    logic [ID_W-1:0]   win_id;

    lpts_min_sel #(.N(NUM_GRPS), .PRI_W(PRI_W), .IDX_W(GIDX_W)) u_top_min (
        .cand_vld (s1_any),
        .cand_pri (s1_pri),
        .any_vld  (s2_hit),
        .best_pri (s2_pri),
        .best_idx (s2_gidx)
    );

    assign s2_lidx = s1_lidx[s2_gidx*LIDX_W +: LIDX_W];
    assign win_id  = ID_W'(s2_gidx) * ID_W'(GROUP_SIZE) + ID_W'(s2_lidx);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_grant_valid <= 1'b0;
            out_miss        <= 1'b0;
            out_core_id     <= '0;
            out_grant_vec   <= '0;
        end else if (load_out) begin
            out_grant_valid <= s2_hit;
            out_miss        <= !s2_hit;
            out_core_id     <= s2_hit ? win_id : '0;
            out_grant_vec   <= s2_hit ? (NUM_CORES'(1) << win_id) : '0;
        end else begin
            out_grant_valid <= 1'b0;
            out_miss        <= 1'b0;
            out_core_id     <= '0;
            out_grant_vec   <= '0;
        end
    end

    AST_WINNER_BELOW_IRQ: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REDUCE && s2_hit) |-> (s2_pri < s1_req_pri)); // R1
    AST_RESULT_TWO_AFTER: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> ##2 (out_grant_valid || out_miss)); // R5
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (rst)
        (out_grant_valid || out_miss) |-> $past(req_valid && req_ready, 2)); // R5
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        out_grant_valid |-> ($countones(out_grant_vec) == 1 && out_grant_vec[out_core_id])); // R6
    AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        out_miss |-> (out_grant_vec == '0 && out_core_id == '0)); // R4
    AST_GRANT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(out_grant_valid && out_miss)); // R10
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_grant_valid && !out_miss && req_ready)); // R9
endmodule

// File: tb/lpri_target_sel_tb_top.sv
`timescale 1ns/1ps
module lpri_target_sel_tb_top;
    localparam int NC = 64;
    localparam int PW = 8;

    logic            clk = 1'b0;
    logic            rst;
    logic            req_valid;
    logic            req_ready;
    logic [NC-1:0]   req_mask;
    logic [PW-1:0]   req_pri;
    logic [NC*PW-1:0] core_pri_bus;
    logic [NC-1:0]   core_rdy;
    logic            out_grant_valid, out_miss;
    logic [5:0]      out_core_id;
    logic [NC-1:0]   out_grant_vec;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    lpri_target_sel dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_mask(req_mask), .req_pri(req_pri), .core_pri_bus(core_pri_bus),
        .core_rdy(core_rdy), .out_grant_valid(out_grant_valid), .out_miss(out_miss),
        .out_core_id(out_core_id), .out_grant_vec(out_grant_vec)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic set_pri(input int i, input logic [7:0] v);
        core_pri_bus[i*PW +: PW] = v;
    endtask

    // reference: returns hit and index of chosen core
    task automatic model(output bit hit, output int idx);
        logic [7:0] best;
        hit = 0; idx = 0; best = 8'hff;
        for (int i = 0; i < NC; i++) begin
            if (req_mask[i] && core_rdy[i] && core_pri_bus[i*PW +: PW] < req_pri) begin
                if (!hit || core_pri_bus[i*PW +: PW] < best) begin
                    hit = 1; idx = i; best = core_pri_bus[i*PW +: PW];
                end
            end
        end
    endtask

    task automatic check_result(input string tag, input bit hit, input int idx);
        chk(out_grant_valid == hit, {tag, " grant_valid"}, 64'(out_grant_valid), 64'(hit));
        chk(out_miss == !hit, {tag, " miss"}, 64'(out_miss), 64'(!hit));
        chk(out_core_id == (hit ? 6'(idx) : 6'd0), {tag, " id"}, 64'(out_core_id), 64'(hit ? idx : 0));
        chk(out_grant_vec == (hit ? (64'd1 << idx) : 64'd0), {tag, " R6 vec"},
            out_grant_vec, hit ? (64'd1 << idx) : 64'd0);
    endtask

    // drive one request, check the busy cycle, result cycle and the cycle after
    task automatic run_req(input string tag, input logic [63:0] m, input logic [7:0] p,
                           output bit hit, output int idx);
        @(negedge clk);
        req_valid = 1; req_mask = m; req_pri = p;
        model(hit, idx);
        chk(req_ready == 1, {tag, " R7 ready before"}, 64'(req_ready), 1);
        @(negedge clk);
        req_valid = 0;
        chk(req_ready == 0, {tag, " R7 busy"}, 64'(req_ready), 0);
        chk(!out_grant_valid && !out_miss, {tag, " R5 early"}, 64'({out_grant_valid, out_miss}), 0);
        @(negedge clk);
        check_result(tag, hit, idx);
        @(negedge clk);
        chk(!out_grant_valid && !out_miss, {tag, " R5 cleared"}, 64'({out_grant_valid, out_miss}), 0);
    endtask

    task automatic clear_cores();
        for (int i = 0; i < NC; i++) set_pri(i, 8'd200);
        core_rdy = '1;
    endtask

    task automatic t_reset();
        rst = 1; req_valid = 1; req_mask = '1; req_pri = 8'hff;
        clear_cores();
        repeat (3) @(negedge clk);
        rst = 0; req_valid = 0;
        chk(!out_grant_valid && !out_miss, "R9 outputs after reset", 64'({out_grant_valid, out_miss}), 0);
        chk(req_ready == 1, "R9 ready after reset", 64'(req_ready), 1);
    endtask

    task automatic t_single();
        bit h; int ix;
        clear_cores(); set_pri(37, 8'd3);
        run_req("R2 single", 64'd1 << 37, 8'd10, h, ix);
        chk(h && ix == 37, "R2 single model", 64'(ix), 37);
    endtask

    task automatic t_lowest();
        bit h; int ix;
        clear_cores();
        set_pri(2, 8'd50); set_pri(19, 8'd7); set_pri(44, 8'd12); set_pri(63, 8'd30);
        run_req("R2 lowest", (64'd1 << 2) | (64'd1 << 19) | (64'd1 << 44) | (64'd1 << 63), 8'd100, h, ix);
        chk(ix == 19, "R2 lowest expected", 64'(ix), 19);
        set_pri(63, 8'd1);
        run_req("R2 top core", (64'd1 << 2) | (64'd1 << 19) | (64'd1 << 63), 8'd100, h, ix);
        chk(ix == 63, "R2 top expected", 64'(ix), 63);
    endtask

    task automatic t_tie();
        bit h; int ix;
        clear_cores();
        set_pri(60, 8'd4); set_pri(12, 8'd4); set_pri(5, 8'd4); set_pri(0, 8'd9);
        run_req("R3 tie", (64'd1 << 60) | (64'd1 << 12) | (64'd1 << 5) | 64'd1, 8'd20, h, ix);
        chk(ix == 5, "R3 tie expected", 64'(ix), 5);
        set_pri(0, 8'd4);
        run_req("R3 tie core0", '1, 8'd20, h, ix);
        chk(ix == 0, "R3 tie0 expected", 64'(ix), 0);
    endtask

    task automatic t_miss();
        bit h; int ix;
        clear_cores();
        set_pri(8, 8'd20);  // equal priority: not eligible
        set_pri(9, 8'd1); core_rdy[9] = 0;  // not ready
        set_pri(10, 8'd1);  // not in mask
        run_req("R1 R4 miss", (64'd1 << 8) | (64'd1 << 9), 8'd20, h, ix);
        chk(!h, "R4 miss expected", 64'(h), 0);
        set_pri(8, 8'd19);
        run_req("R1 one below", (64'd1 << 8) | (64'd1 << 9), 8'd20, h, ix);
        chk(h && ix == 8, "R1 one below expected", 64'(ix), 8);
        set_pri(8, 8'd0);
        run_req("R1 R4 zero irq pri", '1, 8'd0, h, ix);
        chk(!h, "R4 zero pri miss", 64'(h), 0);
    endtask

    task automatic t_sample();
        bit h; int ix;
        clear_cores(); set_pri(30, 8'd5); set_pri(31, 8'd6);
        @(negedge clk);
        req_valid = 1; req_mask = '1; req_pri = 8'd50;
        @(negedge clk);
        req_valid = 0;
        set_pri(30, 8'd90); set_pri(31, 8'd0); core_rdy[30] = 0; req_mask = '0;
        @(negedge clk);
        check_result("R8 sampling", 1, 30);
        @(negedge clk);
    endtask

    task automatic t_b2b();
        clear_cores(); set_pri(11, 8'd2); set_pri(50, 8'd1);
        @(negedge clk);
        req_valid = 1; req_mask = 64'd1 << 11; req_pri = 8'd40;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        check_result("R7 b2b first", 1, 11);
        chk(req_ready == 1, "R7 ready in result cycle", 64'(req_ready), 1);
        req_valid = 1; req_mask = 64'd1 << 50; req_pri = 8'd1;  // equal: miss
        @(negedge clk);
        req_valid = 0;
        chk(!out_grant_valid && !out_miss, "R5 b2b gap", 64'({out_grant_valid, out_miss}), 0);
        chk(req_ready == 0, "R7 b2b busy", 64'(req_ready), 0);
        @(negedge clk);
        check_result("R4 b2b second", 0, 0);
        @(negedge clk);
    endtask

    task automatic t_random();
        logic [63:0] s = 64'h9e3779b97f4a7c15;
        bit h; int ix;
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < NC; i++) begin
                s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
                set_pri(i, 8'(s[15:8] & 8'h3f));
                core_rdy[i] = s[20] | s[21];
            end
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
            run_req("R2 R3 random", s, 8'(s[7:0] & 8'h3f), h, ix);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        core_pri_bus = '0; core_rdy = '0;
        t_reset();
        t_single();
        t_lowest();
        t_tie();
        t_miss();
        t_sample();
        t_b2b();
        t_random();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule